// File: doc/BRIEF.md
# SPI Slave Front End with Pause Control

This block is the serial edge of a memory-style SPI slave. It takes chip select, serial clock, serial data in and an active-low pause pin. It returns serial data out and an enable for the tri-state driver on that line. It runs in SPI mode 0, most significant bit first. Each completed byte is handed to the internal logic with a one-cycle strobe, and the next byte to send is taken from the internal logic at each byte boundary.

All four pins pass through two-flop synchronizers into a system clock that runs at least four times faster than the serial clock. Edges are detected on the synchronized copies. A pause freezes the transfer at its current bit position: the line driver turns off, and clock and data activity is ignored until the pause is released. A pause only starts or ends while the serial clock is low. If chip select is dropped during a pause, the interface state is cleared and an abort pulse goes to the internal logic. A busy flag from an internal write cycle is carried through without regard to the pause.

Top module: `spi_hold_frontend`

## Requirements
- R1: While chip select is high, `miso_oe` is 0 and the bit position is zero, whatever the level of `pause_n`; after reset all outputs are 0.
- R2: On each synchronized rising edge of `sck`, `mosi` is shifted in MSB first. After every eighth such bit outside a pause, `rx_valid` is high for exactly one system clock and `rx_byte` holds the byte.
- R3: `tx_byte` is captured when chip select falls and on the first falling `sck` edge after each eighth bit. `miso` shows its bit 7 first, and the next lower bit after each falling `sck` edge.
- R4: A pause starts when `pause_n` is low with `sck` low. While paused, `miso_oe` is 0 and edges on `sck` and `mosi` have no effect.
- R5: If `pause_n` falls while `sck` is high, `miso_oe` stays 1 until `sck` goes low. The falling edge at that moment still advances `miso`, and the pause then begins.
- R6: If `pause_n` rises while `sck` is low, the pause ends. If it rises while `sck` is high, the pause ends when `sck` next goes low, and that falling edge does not advance `miso`.
- R7: A pause keeps the bit position and the partial receive and transmit bytes, so a byte split by a pause is received and sent intact.
- R8: Chip select rising during a pause clears the bit position and pause state and gives exactly one `abort` pulse.
- R9: A pause can only start after `pause_n` has been seen high while chip select is low. A select that begins with `pause_n` low runs unpaused until `pause_n` goes high and then low again.
- R10: `busy_out` follows `busy_in` one clock later, unaffected by pauses or aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| pause_n | input | 1 | Pause request, active low |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Enable for the external tri-state driver on miso |
| rx_byte | output | W | Last byte received |
| rx_valid | output | 1 | One-clock strobe when rx_byte is new |
| tx_byte | input | W | Next byte to send |
| abort | output | 1 | One-clock pulse when select drops during a pause |
| busy_in | input | 1 | Busy flag from an internal write cycle |
| busy_out | output | 1 | Registered busy flag |

## Verification
On every cycle, the assertions check that a paused interface keeps its bit position and both shift registers unchanged, and that a pause is never active before it has been armed. They also check that an abort leaves a zero bit position and no pause, that the receive strobe lasts a single clock, and that the busy flag is carried through. Only the bench scenarios can show the ordering effects. These are: a pause request made while the clock is high taking effect at the next clock low, the falling edge at pause entry being processed while the one at exit is not, bytes split by pauses in either clock phase arriving intact, and a select that starts with the pause pin low running unpaused.

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sck,
  input  logic         mosi,
  input  logic         pause_n,
  output logic         miso,
  output logic         miso_oe,
  output logic [W-1:0] rx_byte,
  output logic         rx_valid,
  input  logic [W-1:0] tx_byte,
  output logic         abort,
  input  logic         busy_in,
  output logic         busy_out
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [1:0] cs_ff, sck_ff, mosi_ff, pause_ff;
  logic cs_q, sck_q;
  logic paused, armed;
  logic [CW-1:0] cnt;
  logic [W-2:0] rx_sh;
  logic [W-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_ff <= 2'b11; sck_ff <= 2'b00; mosi_ff <= 2'b00; pause_ff <= 2'b11;
      cs_q <= 1'b1; sck_q <= 1'b0;
    end else begin
      cs_ff <= {cs_ff[0], cs_n};
      sck_ff <= {sck_ff[0], sck};
      mosi_ff <= {mosi_ff[0], mosi};
      pause_ff <= {pause_ff[0], pause_n};
      cs_q <= cs_ff[1];
      sck_q <= sck_ff[1];
    end

  wire s_cs_n  = cs_ff[1];
  wire s_sck   = sck_ff[1];
  wire s_mosi  = mosi_ff[1];
  wire s_pause = pause_ff[1];
  wire live    = ~s_cs_n & ~paused;
  wire rise    = live & s_sck & ~sck_q;
  wire fall    = live & ~s_sck & sck_q;
  wire sel_on  = cs_q & ~s_cs_n;

  assign miso_oe = live;
  assign miso    = tx_sh[W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      paused <= 1'b0; armed <= 1'b0; abort <= 1'b0;
    end else begin
      abort <= s_cs_n & paused;
      if (s_cs_n) begin
        paused <= 1'b0;
        armed <= 1'b0;
      end else begin
        if (s_pause) armed <= 1'b1;
        if (!paused && armed && !s_pause && !s_sck) paused <= 1'b1;
        else if (paused && s_pause && !s_sck) paused <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; rx_sh <= '0; rx_byte <= '0; rx_valid <= 1'b0;
      tx_sh <= '0; busy_out <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      busy_out <= busy_in;
      if (s_cs_n) begin
        cnt <= '0;
        rx_sh <= '0;
      end else if (rise) begin
        if (W > 2) rx_sh <= {rx_sh, s_mosi};
        else rx_sh <= s_mosi;
        if (cnt == LAST) begin
          cnt <= '0;
          rx_byte <= {rx_sh, s_mosi};
          rx_valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (sel_on) tx_sh <= tx_byte;
      else if (fall) tx_sh <= (cnt == '0) ? tx_byte : {tx_sh[W-2:0], 1'b0};
    end

  a_r1_idle_position: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs_n |=> (cnt == '0));
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r7_pause_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !s_cs_n) |=> ($stable(cnt) && $stable(tx_sh) && $stable(rx_sh)));
  a_r8_abort_clean: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (cnt == '0 && !paused));
  a_r8_abort_once: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);
  a_r9_pause_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> armed);
  a_r10_busy_carried: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (busy_out == $past(busy_in)));
endmodule

// File: tb/sim_spi_hold_frontend.sv
module sim_spi_hold_frontend;
  localparam int HALF = 8;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, pause_n = 1'b1, busy_in = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic miso, miso_oe, rx_valid, abort, busy_out;
  logic [7:0] rx_byte;

  spi_hold_frontend #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .pause_n(pause_n),
    .miso(miso), .miso_oe(miso_oe), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .tx_byte(tx_byte), .abort(abort), .busy_in(busy_in), .busy_out(busy_out));

  int checks = 0, fails = 0, aborts = 0;
  logic [7:0] exp_q[$];
  bit ended = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (abort) aborts++;
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) chk(0, "R2", "unexpected byte", rx_byte, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_byte == e, "R2", "received byte", rx_byte, e);
      end
    end
  end

  task automatic bit_rise(logic b, logic exp_o, string req);
    mosi = b;
    wclk(HALF);
    chk(miso_oe === 1'b1, req, "oe before rise", miso_oe, 1);
    chk(miso === exp_o, req, "miso bit", miso, exp_o);
    sck = 1'b1;
    wclk(HALF);
  endtask

  task automatic garbage();
    for (int j = 0; j < 3; j++) begin
      mosi = ~mosi;
      sck = 1'b1;
      wclk(HALF);
      chk(miso_oe === 1'b0, "R4", "oe while paused", miso_oe, 0);
      sck = 1'b0;
      wclk(HALF);
    end
  endtask

  task automatic pause_low_phase();
    wclk(HALF);
    pause_n = 1'b0;
    wclk(6);
    chk(miso_oe === 1'b0, "R4", "pause with sck low", miso_oe, 0);
    chk(busy_out === busy_in, "R10", "busy during pause", busy_out, busy_in);
    garbage();
    pause_n = 1'b1;
    wclk(6);
    chk(miso_oe === 1'b1, "R6", "release with sck low", miso_oe, 1);
  endtask

  task automatic pause_high_phase();
    pause_n = 1'b0;
    wclk(6);
    chk(miso_oe === 1'b1, "R5", "no pause while sck high", miso_oe, 1);
    sck = 1'b0;
    wclk(6);
    chk(miso_oe === 1'b0, "R5", "pause after sck low", miso_oe, 0);
    garbage();
    sck = 1'b1;
    wclk(HALF);
    pause_n = 1'b1;
    wclk(6);
    chk(miso_oe === 1'b0, "R6", "still paused, sck high", miso_oe, 0);
    sck = 1'b0;
    wclk(6);
    chk(miso_oe === 1'b1, "R6", "released at sck low", miso_oe, 1);
  endtask

  task automatic xfer(logic [7:0] din, logic [7:0] dout, logic [7:0] nxt,
                      int pause_at, int style, string req);
    exp_q.push_back(din);
    for (int i = 0; i < 8; i++) begin
      bit_rise(din[7-i], dout[7-i], req);
      if (i == 7) tx_byte = nxt;
      if (i == pause_at && style == 1) pause_high_phase();
      sck = 1'b0;
      if (i == pause_at && style == 0) pause_low_phase();
    end
  endtask

  initial begin
    wclk(150000);
    chk(0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(3);
    chk(miso_oe === 1'b0, "R1", "reset oe", miso_oe, 0);
    chk(rx_valid === 1'b0, "R1", "reset rx_valid", rx_valid, 0);
    chk(abort === 1'b0, "R1", "reset abort", abort, 0);
    chk(busy_out === 1'b0, "R1", "reset busy_out", busy_out, 0);

    pause_n = 1'b0;
    wclk(10);
    chk(miso_oe === 1'b0, "R1", "deselected with pause low", miso_oe, 0);
    pause_n = 1'b1;
    wclk(6);

    tx_byte = 8'h3C;
    cs_n = 1'b0;
    wclk(HALF);
    xfer(8'hA5, 8'h3C, 8'hC3, -1, 0, "R2");
    xfer(8'h5A, 8'hC3, 8'h00, -1, 0, "R3");
    wclk(HALF);
    cs_n = 1'b1;
    wclk(HALF);

    busy_in = 1'b1;
    tx_byte = 8'h96;
    cs_n = 1'b0;
    wclk(HALF);
    xfer(8'hC7, 8'h96, 8'h69, 3, 0, "R7");
    xfer(8'h1E, 8'h69, 8'h00, 5, 1, "R7");
    wclk(HALF);
    cs_n = 1'b1;
    wclk(HALF);

    tx_byte = 8'hF0;
    cs_n = 1'b0;
    wclk(HALF);
    for (int k = 0; k < 3; k++) begin
      bit_rise(1'b1, tx_byte[7-k], "R8");
      sck = 1'b0;
    end
    wclk(HALF);
    pause_n = 1'b0;
    wclk(6);
    chk(miso_oe === 1'b0, "R8", "paused before deselect", miso_oe, 0);
    begin
      int a0;
      a0 = aborts;
      cs_n = 1'b1;
      wclk(12);
      chk(aborts == a0 + 1, "R8", "abort pulse count", aborts - a0, 1);
    end
    chk(busy_out === 1'b1, "R10", "busy after abort", busy_out, 1);
    chk(miso_oe === 1'b0, "R8", "oe after abort", miso_oe, 0);

    tx_byte = 8'h4D;
    cs_n = 1'b0;
    wclk(HALF);
    chk(miso_oe === 1'b1, "R9", "select with pause low is unpaused", miso_oe, 1);
    xfer(8'h3B, 8'h4D, 8'h00, -1, 0, "R9");
    wclk(HALF);
    pause_n = 1'b1;
    wclk(6);
    pause_n = 1'b0;
    wclk(6);
    chk(miso_oe === 1'b0, "R9", "fresh pause edge enters pause", miso_oe, 0);
    pause_n = 1'b1;
    wclk(6);
    chk(miso_oe === 1'b1, "R6", "release after fresh pause", miso_oe, 1);
    cs_n = 1'b1;
    busy_in = 1'b0;
    wclk(6);
    chk(busy_out === 1'b0, "R10", "busy cleared", busy_out, 0);
    chk(miso_oe === 1'b0, "R1", "oe off after deselect", miso_oe, 0);

    wclk(20);
    chk(exp_q.size() == 0, "R2", "bytes still expected", exp_q.size(), 0);
    finish_run();
  end
endmodule